// File: doc/BRIEF.md
# Half-Duplex Bus Packet Transmitter

This block sends one framed packet onto a shared, half-duplex differential serial bus and controls the line driver's enable pin. A host first fills a small payload buffer through a byte-wide write port. It then pulses a request together with a destination address, a command code and a payload length. The block raises the driver enable and holds the line at the idle (mark) level for a lead guard time. It then shifts out the whole frame back to back through an internal asynchronous transmitter. The data format is 8 data bits, LSB first, with no parity and one stop bit.

The frame starts with a fixed sync byte. A length byte follows, then the address, the command, the payload bytes and a check byte. After the last stop bit the enable is held for a trail guard time and then released. At that point a one-cycle completion pulse is issued. Guard times and bit timing are derived from the clock frequency, the baud rate and a guard time in microseconds. The enable stays low during and right after reset, so a node that is restarting never holds the bus.

Top module: `bus_pkt_tx`

## Requirements
- R1: While reset is high, and in the first cycle after it, de is 0, txd is 1, busy is 0 and done is 0, whatever the request input does.
- R2: A request sampled while idle makes de and busy go high at that same clock edge.
- R3: After de rises, txd stays high for exactly GUARD = CLK_HZ*GUARD_US/1e6 clock cycles, and then the first start bit begins.
- R4: Each byte takes BIT = CLK_HZ/BAUD cycles per bit: a start bit of 0, then 8 data bits LSB first, then a stop bit of 1. The bytes of one packet follow each other with no gap, so consecutive start bits are 10*BIT cycles apart.
- R5: Bytes are sent in this order: sync 0xAA, length, address, command, payload bytes from buffer index 0 upward, check byte.
- R6: The length byte equals the total packet length in bytes, which is payload length + 5.
- R7: The check byte is the modulo-256 sum of the length, address, command and payload bytes. The sync byte is not part of that sum.
- R8: de falls exactly GUARD cycles after the end of the last stop bit, which is 10*BIT + GUARD cycles after the last start bit begins. txd stays high while de is low.
- R9: done is high for exactly one cycle per packet, at the edge where de falls, and busy falls at that same edge.
- R10: A request that arrives while busy is ignored. The packet in flight is unchanged and no second packet follows.
- R11: A requested payload length above MAX_PAY is treated as MAX_PAY.
- R12: A payload length of 0 gives a 5-byte frame: sync, length, address, command, check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Packet request, sampled while idle |
| req_addr | input | 8 | Destination address byte |
| req_cmd | input | 8 | Command code byte |
| req_len | input | LW | Payload length in bytes |
| buf_we | input | 1 | Payload buffer write strobe |
| buf_idx | input | AW | Payload buffer write index |
| buf_data | input | 8 | Payload buffer write data |
| txd | output | 1 | Serial data to the transceiver driver input |
| de | output | 1 | Transceiver driver enable |
| busy | output | 1 | High from an accepted request until de falls |
| done | output | 1 | One-cycle pulse when a packet is complete |

## Verification
The bench builds the block with CLK_HZ=50 MHz, BAUD=5 MHz and GUARD_US=20. That gives 10 cycles per bit and a 1000-cycle guard, so a full packet with its guards fits in a few thousand cycles and many packets fit in one run. MAX_PAY=8 with a 4-bit length input lets the bench request lengths of 9 to 15, which tests clamping, and also full-buffer and empty-payload frames. A serial monitor decodes txd at mid-bit and time-stamps de edges and start bits, so the guard times and the back-to-back byte spacing are measured cycle by cycle.

// File: rtl/bus_pkt_pkg.sv
package bus_pkt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_SEND  = 2'd2,
    PH_TRAIL = 2'd3
  } phase_t;

  localparam logic [7:0] SYNC_BYTE = 8'hAA;
  localparam int unsigned FIXED_BYTES = 5;
endpackage

// File: rtl/pay_buf.sv
module pay_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ser_tx_core.sv
module ser_tx_core #(
  parameter int BIT_CYC = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] data,
  output logic       txd,
  output logic       fin
);
  localparam int CW = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;

  logic [CW-1:0] bcnt;
  logic [3:0]    nbit;
  logic [8:0]    sh;
  logic          act;
  logic          tick;

  assign tick = act && (bcnt == CW'(BIT_CYC - 1));
  assign fin  = tick && (nbit == 4'd9);

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= 1'b0;
      txd  <= 1'b1;
      bcnt <= '0;
      nbit <= '0;
      sh   <= '1;
    end else if (start && (!act || fin)) begin
      act  <= 1'b1;
      txd  <= 1'b0;
      sh   <= {1'b1, data};
      bcnt <= '0;
      nbit <= '0;
    end else if (act) begin
      if (tick) begin
        bcnt <= '0;
        if (nbit == 4'd9) begin
          act <= 1'b0;
          txd <= 1'b1;
        end else begin
          txd  <= sh[0];
          sh   <= {1'b1, sh[8:1]};
          nbit <= nbit + 4'd1;
        end
      end else begin
        bcnt <= bcnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/bus_pkt_tx.sv
module bus_pkt_tx
  import bus_pkt_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int BAUD     = 115_200,
  parameter int GUARD_US = 1000,
  parameter int MAX_PAY  = 16,
  parameter int LW       = $clog2(MAX_PAY + 1),
  parameter int AW       = $clog2(MAX_PAY)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [7:0]    req_addr,
  input  logic [7:0]    req_cmd,
  input  logic [LW-1:0] req_len,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_idx,
  input  logic [7:0]    buf_data,
  output logic          txd,
  output logic          de,
  output logic          busy,
  output logic          done
);
  localparam int BIT_CYC   = CLK_HZ / BAUD;
  localparam longint GPROD = longint'(CLK_HZ) * longint'(GUARD_US);
  localparam int GUARD_CYC = int'(GPROD / 64'd1_000_000);
  localparam int GW        = $clog2(GUARD_CYC + 1);
  localparam int IW        = $clog2(MAX_PAY + FIXED_BYTES + 1);

  phase_t        phase;
  logic [GW-1:0] gcnt;
  logic [IW-1:0] idx;
  logic [IW-1:0] total;
  logic [7:0]    addr_q;
  logic [7:0]    cmd_q;
  logic [7:0]    sum_q;
  logic [LW-1:0] plen;
  logic [7:0]    pay_rd;
  logic [AW-1:0] rd_idx;
  logic [7:0]    cur_byte;
  logic          start;
  logic          fin;
  logic          guard_end;

  assign plen      = (req_len > LW'(MAX_PAY)) ? LW'(MAX_PAY) : req_len;
  assign rd_idx    = AW'(idx - IW'(4));
  assign guard_end = (gcnt == GW'(GUARD_CYC - 1));

  pay_buf #(.DEPTH(MAX_PAY), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_idx),
    .wdata (buf_data),
    .raddr (rd_idx),
    .rdata (pay_rd)
  );

  always_comb begin
    if (idx == total - IW'(1)) begin
      cur_byte = sum_q;
    end else begin
      case (idx)
        IW'(0):  cur_byte = SYNC_BYTE;
        IW'(1):  cur_byte = 8'(total);
        IW'(2):  cur_byte = addr_q;
        IW'(3):  cur_byte = cmd_q;
        default: cur_byte = pay_rd;
      endcase
    end
  end

  assign start = ((phase == PH_LEAD) && guard_end) ||
                 ((phase == PH_SEND) && fin && (idx != total));

  ser_tx_core #(.BIT_CYC(BIT_CYC)) u_ser (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .data  (cur_byte),
    .txd   (txd),
    .fin   (fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      gcnt   <= '0;
      idx    <= '0;
      total  <= '0;
      addr_q <= '0;
      cmd_q  <= '0;
      sum_q  <= '0;
      de     <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        idx <= idx + IW'(1);
        if (idx != '0) sum_q <= sum_q + cur_byte;
      end
      case (phase)
        PH_IDLE: begin
          if (req) begin
            phase  <= PH_LEAD;
            de     <= 1'b1;
            busy   <= 1'b1;
            gcnt   <= '0;
            idx    <= '0;
            sum_q  <= '0;
            addr_q <= req_addr;
            cmd_q  <= req_cmd;
            total  <= IW'(plen) + IW'(FIXED_BYTES);
          end
        end
        PH_LEAD: begin
          if (guard_end) phase <= PH_SEND;
          else           gcnt  <= gcnt + GW'(1);
        end
        PH_SEND: begin
          if (fin && (idx == total)) begin
            phase <= PH_TRAIL;
            gcnt  <= '0;
          end
        end
        PH_TRAIL: begin
          if (guard_end) begin
            phase <= PH_IDLE;
            de    <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            gcnt <= gcnt + GW'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_pkt_tx_chk.sv
module bus_pkt_tx_chk (
  input logic clk,
  input logic rst,
  input logic txd,
  input logic de,
  input logic busy,
  input logic done
);
  // R1: outputs quiet during reset and the cycle after it
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!de && txd && !busy && !done));

  // R2: enable and busy rise together
  a_r2_de_busy_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(de) |-> $rose(busy));

  // R3: line idle when the enable window opens
  a_r3_lead_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(de) |-> txd);

  // R8: no start bit and no low level outside the enable window
  a_r8_idle_when_released: assert property (@(posedge clk) disable iff (rst)
    !de |-> txd);

  // R9: done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: done marks the enable release and busy drop
  a_r9_done_at_release: assert property (@(posedge clk) disable iff (rst)
    done |-> (!de && !busy && $fell(de)));

  // R10: enable never active outside busy
  a_r10_de_within_busy: assert property (@(posedge clk) disable iff (rst)
    de |-> busy);
endmodule

bind bus_pkt_tx bus_pkt_tx_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .txd  (txd),
  .de   (de),
  .busy (busy),
  .done (done)
);

// File: tb/tb_bus_pkt_tx.sv
module tb_bus_pkt_tx;
  localparam int CLK_HZ   = 50_000_000;
  localparam int BAUD     = 5_000_000;
  localparam int GUARD_US = 20;
  localparam int MAX_PAY  = 8;
  localparam int LW       = 4;
  localparam int AW       = 3;
  localparam int BITC     = CLK_HZ / BAUD;
  localparam int G        = 1000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [7:0]    req_cmd = '0;
  logic [LW-1:0] req_len = '0;
  logic          buf_we = 1'b0;
  logic [AW-1:0] buf_idx = '0;
  logic [7:0]    buf_data = '0;
  logic txd, de, busy, done;

  bus_pkt_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .GUARD_US(GUARD_US),
               .MAX_PAY(MAX_PAY), .LW(LW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_cmd(req_cmd),
    .req_len(req_len), .buf_we(buf_we), .buf_idx(buf_idx), .buf_data(buf_data),
    .txd(txd), .de(de), .busy(busy), .done(done));

  int errs = 0;
  int checks = 0;
  longint cyc = 0;
  logic [7:0] model_pay [0:MAX_PAY-1];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // serial monitor, runs on the falling edge
  logic [7:0] cap [0:31];
  int     cap_n = 0;
  longint t_de_rise = 0, t_de_fall = 0, t_first = 0, t_last = 0;
  int     done_cnt = 0;
  int     rise_cnt = 0;
  bit     frame_err = 0;
  bit     rx_act = 0;
  int     rx_cnt = 0;
  logic [7:0] rx_sh = '0;
  logic   prev_de = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (de && !prev_de) begin t_de_rise = cyc; rise_cnt++; end
      if (!de && prev_de) t_de_fall = cyc;
      if (done) done_cnt++;
      if (!rx_act) begin
        if (txd == 1'b0) begin
          rx_act = 1;
          rx_cnt = 0;
          if (cap_n == 0) t_first = cyc;
          t_last = cyc;
        end
      end else begin
        rx_cnt++;
        if (rx_cnt % BITC == BITC / 2) begin
          if (rx_cnt / BITC <= 8) begin
            rx_sh = {txd, rx_sh[7:1]};
          end else begin
            if (txd !== 1'b1) frame_err = 1;
            if (cap_n < 32) cap[cap_n] = rx_sh;
            cap_n++;
            rx_act = 0;
          end
        end
      end
    end
    prev_de = de;
  end

  task automatic clear_mon();
    cap_n = 0; done_cnt = 0; rise_cnt = 0; frame_err = 0;
  endtask

  task automatic wr_pay(input int i, input logic [7:0] d);
    buf_we = 1'b1; buf_idx = AW'(i); buf_data = d;
    @(posedge clk); #2;
    buf_we = 1'b0;
    model_pay[i] = d;
  endtask

  function automatic logic [7:0] exp_byte(input int i, input int n,
                                          input logic [7:0] a, input logic [7:0] c);
    logic [7:0] s;
    if (i == 0) return 8'hAA;
    if (i == 1) return 8'(n + 5);
    if (i == 2) return a;
    if (i == 3) return c;
    if (i < n + 4) return model_pay[i-4];
    s = 8'(n + 5) + a + c;
    for (int k = 0; k < n; k++) s = s + model_pay[k];
    return s;
  endfunction

  task automatic run_pkt(input logic [7:0] a, input logic [7:0] c,
                         input int n, input bit extra);
    int neff;
    int w;
    int snap;
    neff = (n > MAX_PAY) ? MAX_PAY : n;
    clear_mon();
    req = 1'b1; req_addr = a; req_cmd = c; req_len = LW'(n);
    @(posedge clk); #2;
    req = 1'b0;
    check(de === 1'b1, "R2", "de after request", de, 1);
    check(busy === 1'b1, "R2", "busy after request", busy, 1);
    if (extra) begin
      repeat (300) @(posedge clk);
      #2;
      req = 1'b1; req_addr = ~a; req_cmd = ~c; req_len = LW'(1);
      @(posedge clk); #2;
      req = 1'b0;
    end
    w = 0;
    while (done_cnt == 0 && w < 20000) begin @(posedge clk); #2; w++; end
    repeat (3) @(posedge clk);
    #2;
    check(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    check(t_de_fall == t_de_rise + 10 * BITC * (neff + 5) - BITC * 10 + 10 * BITC + 2 * G,
          "R9", "de window length", t_de_fall - t_de_rise,
          10 * BITC * (neff + 5) + 2 * G);
    check(busy === 1'b0 && de === 1'b0, "R9", "busy and de after done", {busy, de}, 0);
    check(cap_n == neff + 5, (n == 0) ? "R12" : (n > MAX_PAY) ? "R11" : "R6",
          "byte count", cap_n, neff + 5);
    check(frame_err == 0, "R4", "stop bit level", frame_err, 0);
    check(t_first - t_de_rise == G, "R3", "lead guard cycles", t_first - t_de_rise, G);
    check(t_last - t_first == longint'(10 * BITC * (neff + 4)), "R4", "byte spacing",
          t_last - t_first, 10 * BITC * (neff + 4));
    check(t_de_fall - t_last == 10 * BITC + G, "R8", "trail guard", t_de_fall - t_last,
          10 * BITC + G);
    for (int i = 0; i < neff + 5 && i < 32; i++) begin
      logic [7:0] e;
      e = exp_byte(i, neff, a, c);
      check(cap[i] == e,
            (i == 0) ? "R5" : (i == 1) ? "R6" : (i == neff + 4) ? "R7" : "R5",
            $sformatf("byte %0d", i), cap[i], e);
    end
    if (extra) begin
      snap = cap_n;
      repeat (G + 400) @(posedge clk);
      #2;
      check(rise_cnt == 1 && cap_n == snap && de === 1'b0, "R10",
            "no second packet", rise_cnt, 1);
    end
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < MAX_PAY; i++) model_pay[i] = '0;
    req = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check(de === 1'b0, "R1", "de in reset", de, 0);
    check(txd === 1'b1, "R1", "txd in reset", txd, 1);
    check(busy === 1'b0, "R1", "busy in reset", busy, 0);
    check(done === 1'b0, "R1", "done in reset", done, 0);
    rst = 1'b0; req = 1'b0;
    @(posedge clk); #2;
    check(de === 1'b0 && txd === 1'b1, "R1", "de/txd after reset", {de, txd}, 1);
    for (int i = 0; i < MAX_PAY; i++) wr_pay(i, 8'(8'h10 + i * 17));
    // directed corners
    run_pkt(8'h01, 8'h03, 0, 0);          // R12 empty payload
    run_pkt(8'hFF, 8'hFF, MAX_PAY, 0);    // R7 checksum wrap
    run_pkt(8'h22, 8'h44, 13, 0);         // R11 clamp
    run_pkt(8'h5A, 8'hA5, 3, 1);          // R10 request while busy
    // random packets
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < MAX_PAY; i++) wr_pay(i, 8'($urandom));
      run_pkt(8'($urandom), 8'($urandom), int'($urandom % 16), 0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule